// File: doc/BRIEF.md
# Block memory move engine

This block copies a run of bytes from one place in a 24-bit address space to another. The space is split into an 8-bit bank and a 16-bit offset. A caller gives it a source offset, a destination offset, a source bank, a destination bank, a length written as count minus one, and a direction. The block then moves one byte at a time through a simple synchronous memory port: one cycle reads from the source, and the next cycle writes that byte to the destination.

Offsets step by one after every byte. They rise in forward mode and fall in backward mode, and they wrap inside 16 bits without touching the bank. Backward mode lets a copy whose destination lies above its source overlap that source safely. When the count wraps from zero to all ones, the engine raises a one-cycle done pulse. It also leaves the final source offset, destination offset and count on its outputs so the caller can write them back to its index and accumulator registers, and it presents the destination bank as the new data bank.

Top module: `blkmove_engine`

## Requirements
- R1: While reset is asserted and immediately after it, busy, done, mem_rd and mem_wr are low, and src_final, dst_final, cnt_final and dbank_out are zero.
- R2: A move started with length field L transfers exactly L+1 bytes, so L = 0 moves one byte. At the done pulse cnt_final is all ones (16'hFFFF).
- R3: Each byte takes a read cycle followed by a write cycle. mem_rd and mem_wr are never high together. The byte written is the mem_rdata returned in the cycle after the read strobe. A move of N bytes raises done in cycle 2N+1 after start is sampled.
- R4: Read addresses are {src_bank, source offset} and write addresses are {dst_bank, destination offset}, with the bank in bits 23:16.
- R5: With dir_back = 0 both offsets rise by one after each byte. With dir_back = 1 both fall by one. A backward copy whose destination is above its overlapping source reproduces the original source bytes at the destination.
- R6: Offsets wrap modulo 2^16 (FFFF to 0000 forward, 0000 to FFFF backward), and the bank part of the address never changes during a move.
- R7: busy is high from the cycle after start is sampled until the done pulse. done is high for exactly one cycle with busy low, and the engine is idle in the following cycle.
- R8: A start pulse while busy is ignored. The running move finishes with its original addresses, length, direction and banks.
- R9: At the done pulse and afterwards, dbank_out equals the destination bank given at start.
- R10: At the done pulse src_final and dst_final equal the start offsets plus N (forward) or minus N (backward), modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a move (sampled when idle) |
| dir_back | input | 1 | 0 = offsets rise, 1 = offsets fall |
| src_start | input | 16 | First source offset |
| dst_start | input | 16 | First destination offset |
| len_m1 | input | 16 | Number of bytes minus one |
| src_bank | input | 8 | Source bank |
| dst_bank | input | 8 | Destination bank |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |
| mem_addr | output | 24 | Memory address {bank, offset} |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle completion pulse |
| src_final | output | 16 | Source offset after the move |
| dst_final | output | 16 | Destination offset after the move |
| cnt_final | output | 16 | Length field after the move |
| dbank_out | output | 8 | Data bank, set to the destination bank at completion |

## Verification
The bench builds the engine with its default widths: 16-bit offsets, 8-bit banks and 8-bit data. Because of this, the offset wrap at FFFF/0000 is reached by a move of a few bytes that starts near the edge, and any leak into the bank shows up directly in bits 23:16 of the address. A shadow copy of memory predicts every read address and every written byte in order. This covers overlapping backward copies and one-byte moves, and it also covers a start pulse given mid-move with different operands, which must leave the running move unchanged.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;
    typedef enum logic [1:0] {
        MV_IDLE  = 2'd0,
        MV_READ  = 2'd1,
        MV_WRITE = 2'd2,
        MV_DONE  = 2'd3
    } mv_state_e;
endpackage

// File: rtl/blkmove_ofs_step.sv
// Offset stepper: moves an offset one place up or down, wrapping in W bits.
module blkmove_ofs_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] ofs,
    input  logic         back,
    output logic [W-1:0] ofs_nxt
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        if (back) ofs_nxt = ofs - ONE;
        else      ofs_nxt = ofs + ONE;
    end
endmodule

// File: rtl/blkmove_cnt_step.sv
// Length counter step: decrements and flags the byte that makes it wrap.
module blkmove_cnt_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt,
    output logic [W-1:0] cnt_nxt,
    output logic         last
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    assign cnt_nxt = cnt - ONE;
    assign last    = (cnt == '0);
endmodule

// File: rtl/blkmove_engine.sv
module blkmove_engine #(
    parameter int OFS_W  = 16,
    parameter int BANK_W = 8,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    dir_back,
    input  logic [OFS_W-1:0]        src_start,
    input  logic [OFS_W-1:0]        dst_start,
    input  logic [OFS_W-1:0]        len_m1,
    input  logic [BANK_W-1:0]       src_bank,
    input  logic [BANK_W-1:0]       dst_bank,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic [BANK_W+OFS_W-1:0] mem_addr,
    output logic                    mem_rd,
    output logic                    mem_wr,
    output logic [DATA_W-1:0]       mem_wdata,
    output logic                    busy,
    output logic                    done,
    output logic [OFS_W-1:0]        src_final,
    output logic [OFS_W-1:0]        dst_final,
    output logic [OFS_W-1:0]        cnt_final,
    output logic [BANK_W-1:0]       dbank_out
);
    import blkmove_pkg::*;

    localparam int ADDR_W = BANK_W + OFS_W;

    typedef struct packed {
        mv_state_e         st;
        logic              back;
        logic [BANK_W-1:0] sbank;
        logic [BANK_W-1:0] wbank;
        logic [OFS_W-1:0]  src;
        logic [OFS_W-1:0]  dst;
        logic [OFS_W-1:0]  cnt;
        logic [BANK_W-1:0] dbank;
    } mv_regs_t;

    mv_regs_t r_d, r_q;

    logic [OFS_W-1:0] src_nxt, dst_nxt, cnt_nxt;
    logic             cnt_last;

    blkmove_ofs_step #(.W(OFS_W)) u_src_step (
        .ofs(r_q.src), .back(r_q.back), .ofs_nxt(src_nxt)
    );
    blkmove_ofs_step #(.W(OFS_W)) u_dst_step (
        .ofs(r_q.dst), .back(r_q.back), .ofs_nxt(dst_nxt)
    );
    blkmove_cnt_step #(.W(OFS_W)) u_cnt_step (
        .cnt(r_q.cnt), .cnt_nxt(cnt_nxt), .last(cnt_last)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            MV_IDLE: begin
                if (start) begin
                    r_d.st    = MV_READ;
                    r_d.back  = dir_back;
                    r_d.sbank = src_bank;
                    r_d.wbank = dst_bank;
                    r_d.src   = src_start;
                    r_d.dst   = dst_start;
                    r_d.cnt   = len_m1;
                end
            end
            MV_READ: begin
                r_d.st = MV_WRITE;
            end
            MV_WRITE: begin
                r_d.src = src_nxt;
                r_d.dst = dst_nxt;
                r_d.cnt = cnt_nxt;
                if (cnt_last) begin
                    r_d.st    = MV_DONE;
                    r_d.dbank = r_q.wbank;
                end else begin
                    r_d.st = MV_READ;
                end
            end
            default: begin
                r_d.st = MV_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_rd    = (r_q.st == MV_READ);
    assign mem_wr    = (r_q.st == MV_WRITE);
    assign mem_addr  = mem_rd ? ADDR_W'({r_q.sbank, r_q.src})
                              : ADDR_W'({r_q.wbank, r_q.dst});
    assign mem_wdata = mem_rdata;
    assign busy      = mem_rd | mem_wr;
    assign done      = (r_q.st == MV_DONE);
    assign src_final = r_q.src;
    assign dst_final = r_q.dst;
    assign cnt_final = r_q.cnt;
    assign dbank_out = r_q.dbank;
endmodule

// File: rtl/blkmove_engine_chk.sv
module blkmove_engine_chk #(
    parameter int OFS_W  = 16,
    parameter int BANK_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              busy,
    input logic              done,
    input logic [OFS_W-1:0]  cnt_final,
    input logic [BANK_W-1:0] dbank_out
);
    p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_wr_follows_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_wr);

    p_cnt_wrapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt_final == {OFS_W{1'b1}}));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_start_begins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> (busy && mem_rd));

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> (busy || done));

    p_dbank_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !busy) |=> $stable(dbank_out));
endmodule

bind blkmove_engine blkmove_engine_chk #(.OFS_W(OFS_W), .BANK_W(BANK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .busy(busy), .done(done), .cnt_final(cnt_final), .dbank_out(dbank_out)
);

// File: tb/blkmove_engine_tb_top.sv
module blkmove_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir_back = 1'b0;
    logic [15:0] src_start = '0, dst_start = '0, len_m1 = '0;
    logic [7:0]  src_bank = '0, dst_bank = '0;
    logic [7:0]  mem_rdata = '0;
    logic [23:0] mem_addr;
    logic        mem_rd, mem_wr, busy, done;
    logic [7:0]  mem_wdata, dbank_out;
    logic [15:0] src_final, dst_final, cnt_final;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    blkmove_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_back(dir_back),
        .src_start(src_start), .dst_start(dst_start), .len_m1(len_m1),
        .src_bank(src_bank), .dst_bank(dst_bank), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .busy(busy), .done(done),
        .src_final(src_final), .dst_final(dst_final),
        .cnt_final(cnt_final), .dbank_out(dbank_out)
    );

    typedef struct {
        logic [23:0] a;
        logic [7:0]  d;
    } wr_item_t;

    logic [7:0]  mem    [int unsigned];
    logic [7:0]  shadow [int unsigned];
    logic [23:0] rd_q[$];
    wr_item_t    wr_q[$];

    function automatic logic [7:0] seed_byte(logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] mem_get(logic [23:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return seed_byte(a);
    endfunction

    function automatic logic [7:0] sh_get(logic [23:0] a);
        if (shadow.exists(int'(a))) return shadow[int'(a)];
        return seed_byte(a);
    endfunction

    // memory model: read data returned one cycle after the strobe
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem_get(mem_addr);
        if (mem_wr) mem[int'(mem_addr)] = mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: compare every read address and write against the scoreboard
    always @(negedge clk) begin
        if (rst_n && mem_rd) begin
            if (rd_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected read", mem_addr, 0);
            end else begin
                logic [23:0] ea;
                ea = rd_q.pop_front();
                chk(mem_addr == ea, "R4", "read address (R5 R6)", mem_addr, ea);
            end
        end
        if (rst_n && mem_wr) begin
            if (wr_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected write", mem_addr, 0);
            end else begin
                wr_item_t e;
                e = wr_q.pop_front();
                chk(mem_addr == e.a, "R4", "write address (R5 R6)", mem_addr, e.a);
                chk(mem_wdata == e.d, "R3", "write data", mem_wdata, e.d);
            end
        end
    end

    // driver: predict, start, wait for completion, check results
    task automatic run_move(input logic [15:0] s, input logic [15:0] d,
                            input logic [15:0] l, input logic [7:0] sb,
                            input logic [7:0] db, input bit bk, input bit poke);
        int          n;
        int          cyc;
        bit          busy_gap;
        logic [15:0] ps, pd, es, ed;
        n  = int'(l) + 1;
        ps = s;
        pd = d;
        for (int i = 0; i < n; i++) begin
            wr_item_t it;
            it.a = {db, pd};
            it.d = sh_get({sb, ps});
            shadow[int'(it.a)] = it.d;
            rd_q.push_back({sb, ps});
            wr_q.push_back(it);
            ps = bk ? ps - 16'd1 : ps + 16'd1;
            pd = bk ? pd - 16'd1 : pd + 16'd1;
        end
        es = bk ? s - 16'(n) : s + 16'(n);
        ed = bk ? d - 16'(n) : d + 16'(n);

        @(negedge clk);
        src_start = s; dst_start = d; len_m1 = l;
        src_bank = sb; dst_bank = db; dir_back = bk;
        start = 1'b1;
        cyc = 0;
        busy_gap = 1'b0;
        do begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) start = 1'b0;
            if (poke && cyc == 2) begin
                start = 1'b1;
                src_start = 16'hDEAD; dst_start = 16'hBEEF; len_m1 = 16'd0;
                src_bank = 8'hEE; dst_bank = 8'hEF; dir_back = ~bk;
            end
            if (poke && cyc == 3) start = 1'b0;
            if (!done && !busy) busy_gap = 1'b1;
        end while (!done && cyc < 5000);

        chk(done, "R7", "done pulse seen", done, 1);
        chk(!busy_gap, "R7", "busy high until done", busy_gap, 0);
        chk(cyc == 2 * n + 1, "R3", "cycles to done", cyc, 2 * n + 1);
        chk(!busy, "R7", "busy low at done", busy, 0);
        chk(cnt_final == 16'hFFFF, "R2", "count after move", cnt_final, 16'hFFFF);
        chk(wr_q.size() == 0, "R2", "bytes left unwritten", wr_q.size(), 0);
        chk(src_final == es, "R10", "final source offset", src_final, es);
        chk(dst_final == ed, "R10", "final destination offset", dst_final, ed);
        chk(dbank_out == db, "R9", "data bank at done", dbank_out, db);
        if (poke) chk(dbank_out == db, "R8", "bank after ignored start", dbank_out, db);
        @(negedge clk);
        chk(!done && !busy, "R7", "idle after done", {busy, done}, 0);
        chk(dbank_out == db, "R9", "data bank held", dbank_out, db);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_rd && !mem_wr, "R1", "control in reset",
            {busy, done, mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_rd && !mem_wr, "R1", "control after reset",
            {busy, done, mem_rd, mem_wr}, 0);
        chk(src_final == 0 && dst_final == 0, "R1", "offsets after reset",
            {src_final, dst_final}, 0);
        chk(cnt_final == 0 && dbank_out == 0, "R1", "count and bank after reset",
            {cnt_final, dbank_out}, 0);

        run_move(16'h1000, 16'h2000, 16'd7, 8'h01, 8'h02, 1'b0, 1'b0); // R5 forward
        run_move(16'h0050, 16'h0060, 16'd0, 8'h03, 8'h03, 1'b0, 1'b0); // R2 single byte
        run_move(16'hFFFE, 16'hFFFD, 16'd4, 8'h7E, 8'h7F, 1'b0, 1'b0); // R6 forward wrap
        run_move(16'h0100, 16'h0102, 16'd5, 8'h10, 8'h10, 1'b1, 1'b0); // R5 overlap backward
        run_move(16'h0001, 16'h8000, 16'd3, 8'h40, 8'h41, 1'b1, 1'b0); // R6 backward wrap
        run_move(16'h3000, 16'h3100, 16'd5, 8'h20, 8'h21, 1'b0, 1'b1); // R8 start while busy

        for (int i = 0; i < 6; i++) begin
            logic [23:0] a;
            a = {8'h10, 16'h0102 - 16'(i)};
            chk(mem_get(a) == seed_byte({8'h10, 16'h0100 - 16'(i)}), "R5",
                "overlapped copy content", mem_get(a),
                seed_byte({8'h10, 16'h0100 - 16'(i)}));
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R7 watchdog expired: actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule